// File: doc/BRIEF.md
# Receive Staging FIFO with Lossy/Lossless Admission

This block sits between the receive side of an Ethernet MAC and the engine that enqueues frames into receive descriptor rings. Each incoming frame is written, one byte per beat, into a local staging store. It becomes visible to the drain side only once its last byte has arrived and the frame has been accepted. Alongside the bytes, a small descriptor queue records each accepted frame's length and target ring. A frame that cannot fit is refused as a whole.

The drain side looks at the oldest frame and samples that ring's free-buffer flag. If a buffer is free, the frame is streamed out. If no buffer is free, the ring's congestion mode decides what happens. In lossy mode the frame is discarded in a single cycle by jumping the read pointer over its stored length. In lossless mode the frame stays in place, and so does everything queued behind it, until a buffer appears.

The per-ring mode is loaded from the transmit-pause setting of the link when a configuration apply strobe is seen: pause on selects lossless mode, pause off selects lossy mode. A running count of the receive bytes held is exported so that a PAUSE generator can compare it with its on and off thresholds.

Top module: `rx_stage_admit`

## Requirements
- R1: After reset the byte occupancy is 0, `out_valid`, `drop_ovf` and `drop_nobuf` are low, and every ring is in lossy mode (`ring_lossless` all zero).
- R2: A frame whose ring has a free buffer when it reaches the head is output on consecutive cycles. Its bytes come out unchanged and in order, `out_ring` equals the index given on `in_ring` with the last byte, and `out_last` is high on the final byte only.
- R3: `occ_bytes` rises by a frame's length in the cycle after its last byte is accepted. It falls by that length in the cycle after the frame's final byte is output or the frame is discarded. It never exceeds DEPTH and holds its value when neither event occurs.
- R4: In lossy mode (ring_lossless bit 0), a head frame whose ring has no free buffer is discarded without putting any byte on the output. `drop_nobuf` pulses for one cycle per discarded frame.
- R5: In lossless mode (ring_lossless bit 1), a head frame whose ring has no free buffer is kept, with no output and no `drop_nobuf` pulse. Its bytes remain counted, and it is output once the ring's `ring_free` bit is 1.
- R6: A cycle with `cfg_apply` high sets every bit of `ring_lossless` to `cfg_tx_pause` on the next cycle. Changes of `cfg_tx_pause` while `cfg_apply` is low have no effect.
- R7: A frame that would take occupancy above DEPTH, or that arrives while DESC_DEPTH frames are already queued, is refused whole. `drop_ovf` pulses for one cycle, occupancy is not increased, and none of its bytes are ever output.
- R8: A frame longer than MAX_LEN bytes is refused in the same way as in R7, while a frame of exactly MAX_LEN bytes is accepted.
- R9: Frames leave strictly in arrival order. A lossless head frame that is waiting for a buffer also holds back later frames whose rings do have free buffers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tx_pause | input | 1 | Transmit-pause setting of the link |
| cfg_apply | input | 1 | Loads the ring modes from cfg_tx_pause |
| in_valid | input | 1 | Receive byte valid |
| in_data | input | DATA_W | Receive byte |
| in_last | input | 1 | Final byte of the frame |
| in_ring | input | RW | Target ring of the frame, sampled with the last byte |
| ring_free | input | NUM_RINGS | Per-ring free-buffer flag |
| out_valid | output | 1 | Output byte valid |
| out_data | output | DATA_W | Output byte |
| out_last | output | 1 | Final byte of the output frame |
| out_ring | output | RW | Ring of the frame being output |
| occ_bytes | output | OCW | Receive bytes held |
| drop_ovf | output | 1 | Pulse: frame refused at the input |
| drop_nobuf | output | 1 | Pulse: head frame discarded for lack of a buffer |
| ring_lossless | output | NUM_RINGS | Current per-ring mode (1 = lossless) |

## Verification
The table-driven part sends frames of one byte, of the maximum length and of intermediate lengths. Each frame is sent under every pairing of mode and buffer availability, so delivery, lossy discard and lossless hold-then-release can be told apart by output bytes, pulse counts and occupancy. Directed sequences fill the store past DEPTH and the descriptor queue past DESC_DEPTH, and send a frame one byte over the limit. These separate refusal at the input from discard at the head. A two-frame sequence with only the second frame's ring free shows that the drain never overtakes a blocked head.

// File: rtl/rxa_pkg.sv
package rxa_pkg;

  typedef enum logic {DR_IDLE, DR_SEND} drain_st_e;

  // Byte occupancy after one cycle of accept and release events.
  function automatic logic [31:0] occ_update(input logic [31:0] occ,
                                             input logic        add,
                                             input logic [31:0] add_len,
                                             input logic        sub,
                                             input logic [31:0] sub_len);
    logic [31:0] v;
    v = occ;
    if (add) v = v + add_len;
    if (sub) v = v - sub_len;
    return v;
  endfunction

  // True when a frame holding cnt bytes still fits alongside occ held bytes.
  function automatic logic beat_fits(input logic [31:0] occ,
                                     input logic [31:0] cnt,
                                     input logic [31:0] depth,
                                     input logic [31:0] max_len);
    return ((occ + cnt) <= depth) && (cnt <= max_len);
  endfunction

endpackage

// File: rtl/rxa_byte_store.sv
module rxa_byte_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rxa_desc_q.sv
module rxa_desc_q #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  logic [W-1:0] slot [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) slot[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = slot[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == (PW+1)'(DEPTH));
endmodule

// File: rtl/rxa_ingress.sv
module rxa_ingress
  import rxa_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DEPTH   = 64,
  parameter int MAX_LEN = 32,
  localparam int AW     = $clog2(DEPTH),
  localparam int LW     = $clog2(MAX_LEN + 1),
  localparam int OCW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  input  logic [OCW-1:0]    occ,
  input  logic              desc_full,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              commit_evt,
  output logic              ovf_evt,
  output logic [LW-1:0]     commit_len
);
  logic [LW:0]   wr_cnt, cnt_after;
  logic          ovf_flag, fits, frame_end, frame_bad;
  logic [AW-1:0] wr_base;

  always_comb begin
    cnt_after  = wr_cnt + 1'b1;
    fits       = beat_fits(32'(occ), 32'(cnt_after), 32'(DEPTH), 32'(MAX_LEN));
    frame_end  = in_valid && in_last;
    frame_bad  = ovf_flag || !fits || desc_full;
    wr_en      = in_valid && !ovf_flag && fits;
    wr_addr    = wr_base + AW'(wr_cnt);
    wr_data    = in_data;
    commit_evt = frame_end && !frame_bad;
    ovf_evt    = frame_end && frame_bad;
    commit_len = cnt_after[LW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_cnt   <= '0;
      ovf_flag <= 1'b0;
      wr_base  <= '0;
    end else if (frame_end) begin
      wr_cnt   <= '0;
      ovf_flag <= 1'b0;
      if (commit_evt) wr_base <= wr_base + AW'(cnt_after);
    end else if (in_valid) begin
      if (!ovf_flag && fits) wr_cnt <= cnt_after;
      else                   ovf_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/rxa_drain.sv
module rxa_drain
  import rxa_pkg::*;
#(
  parameter int NUM_RINGS = 4,
  parameter int AW        = 6,
  parameter int LW        = 6,
  localparam int RW       = (NUM_RINGS > 1) ? $clog2(NUM_RINGS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 head_valid,
  input  logic [RW-1:0]        head_ring,
  input  logic [LW-1:0]        head_len,
  input  logic [NUM_RINGS-1:0] ring_free,
  input  logic [NUM_RINGS-1:0] ring_lossless,
  output logic [AW-1:0]        rd_addr,
  output logic                 out_valid,
  output logic                 out_last,
  output logic                 release_evt,
  output logic                 nobuf_evt,
  output logic                 head_blocked
);
  drain_st_e     st;
  logic [AW-1:0] rd_ptr;
  logic [LW-1:0] left;
  logic          idle, head_free, head_lossless, start;

  always_comb begin
    idle          = (st == DR_IDLE);
    head_free     = ring_free[head_ring];
    head_lossless = ring_lossless[head_ring];
    start         = idle && head_valid && head_free;
    nobuf_evt     = idle && head_valid && !head_free && !head_lossless;
    head_blocked  = idle && head_valid && !head_free && head_lossless;
    out_valid     = (st == DR_SEND);
    out_last      = out_valid && (left == LW'(1));
    release_evt   = nobuf_evt || out_last;
    rd_addr       = rd_ptr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= DR_IDLE;
      rd_ptr <= '0;
      left   <= '0;
    end else if (idle) begin
      if (start) begin
        st   <= DR_SEND;
        left <= head_len;
      end else if (nobuf_evt) begin
        rd_ptr <= rd_ptr + AW'(head_len);
      end
    end else begin
      rd_ptr <= rd_ptr + 1'b1;
      left   <= left - 1'b1;
      if (out_last) st <= DR_IDLE;
    end
  end
endmodule

// File: rtl/rx_stage_admit.sv
module rx_stage_admit
  import rxa_pkg::*;
#(
  parameter int NUM_RINGS  = 4,
  parameter int DATA_W     = 8,
  parameter int DEPTH      = 64,
  parameter int MAX_LEN    = 32,
  parameter int DESC_DEPTH = 4,
  localparam int RW        = (NUM_RINGS > 1) ? $clog2(NUM_RINGS) : 1,
  localparam int AW        = $clog2(DEPTH),
  localparam int LW        = $clog2(MAX_LEN + 1),
  localparam int OCW       = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_tx_pause,
  input  logic                 cfg_apply,
  input  logic                 in_valid,
  input  logic [DATA_W-1:0]    in_data,
  input  logic                 in_last,
  input  logic [RW-1:0]        in_ring,
  input  logic [NUM_RINGS-1:0] ring_free,
  output logic                 out_valid,
  output logic [DATA_W-1:0]    out_data,
  output logic                 out_last,
  output logic [RW-1:0]        out_ring,
  output logic [OCW-1:0]       occ_bytes,
  output logic                 drop_ovf,
  output logic                 drop_nobuf,
  output logic [NUM_RINGS-1:0] ring_lossless
);
  // Named internal events, also observed by the bound checker.
  logic                 commit_evt, ovf_evt, release_evt, nobuf_evt, head_blocked;
  logic [LW-1:0]        commit_len;
  logic                 wr_en;
  logic [AW-1:0]        wr_addr, rd_addr;
  logic [DATA_W-1:0]    wr_data;
  logic                 dq_empty, dq_full;
  logic [RW+LW-1:0]     dq_head;
  logic [RW-1:0]        head_ring;
  logic [LW-1:0]        head_len;
  logic [OCW-1:0]       occ_q;
  logic [NUM_RINGS-1:0] mode_q;
  logic                 ovf_q, nobuf_q;

  rxa_ingress #(.DATA_W(DATA_W), .DEPTH(DEPTH), .MAX_LEN(MAX_LEN)) u_ingress (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .occ(occ_q), .desc_full(dq_full),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit_evt(commit_evt), .ovf_evt(ovf_evt), .commit_len(commit_len)
  );

  rxa_byte_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(out_data)
  );

  rxa_desc_q #(.W(RW + LW), .DEPTH(DESC_DEPTH)) u_descq (
    .clk(clk), .rst_n(rst_n),
    .push(commit_evt), .din({in_ring, commit_len}),
    .pop(release_evt), .dout(dq_head),
    .empty(dq_empty), .full(dq_full)
  );

  assign head_ring = dq_head[RW+LW-1:LW];
  assign head_len  = dq_head[LW-1:0];

  rxa_drain #(.NUM_RINGS(NUM_RINGS), .AW(AW), .LW(LW)) u_drain (
    .clk(clk), .rst_n(rst_n),
    .head_valid(!dq_empty), .head_ring(head_ring), .head_len(head_len),
    .ring_free(ring_free), .ring_lossless(mode_q),
    .rd_addr(rd_addr), .out_valid(out_valid), .out_last(out_last),
    .release_evt(release_evt), .nobuf_evt(nobuf_evt), .head_blocked(head_blocked)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_q   <= '0;
      mode_q  <= '0;
      ovf_q   <= 1'b0;
      nobuf_q <= 1'b0;
    end else begin
      occ_q   <= OCW'(occ_update(32'(occ_q), commit_evt, 32'(commit_len),
                                 release_evt, 32'(head_len)));
      ovf_q   <= ovf_evt;
      nobuf_q <= nobuf_evt;
      if (cfg_apply) mode_q <= {NUM_RINGS{cfg_tx_pause}};
    end
  end

  assign out_ring      = head_ring;
  assign occ_bytes     = occ_q;
  assign drop_ovf      = ovf_q;
  assign drop_nobuf    = nobuf_q;
  assign ring_lossless = mode_q;
endmodule

// File: rtl/rx_stage_admit_chk.sv
module rx_stage_admit_chk #(
  parameter int NUM_RINGS = 4,
  parameter int DEPTH     = 64,
  parameter int OCW       = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_apply,
  input logic                 cfg_tx_pause,
  input logic [NUM_RINGS-1:0] ring_lossless,
  input logic [OCW-1:0]       occ_bytes,
  input logic                 out_valid,
  input logic                 out_last,
  input logic                 drop_ovf,
  input logic                 drop_nobuf,
  input logic                 commit_evt,
  input logic                 ovf_evt,
  input logic                 release_evt,
  input logic                 nobuf_evt,
  input logic                 head_blocked
);
  assert_last_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  assert_occ_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    occ_bytes <= OCW'(DEPTH));

  assert_occ_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit_evt && !release_evt) |=> $stable(occ_bytes));

  assert_lossy_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    nobuf_evt |=> (drop_nobuf && !out_valid));

  assert_lossless_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    head_blocked |=> (!out_valid && !drop_nobuf));

  assert_mode_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_apply |=> (ring_lossless == {NUM_RINGS{$past(cfg_tx_pause)}}));

  assert_mode_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_apply |=> $stable(ring_lossless));

  assert_refuse_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> drop_ovf);

  assert_refuse_no_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |-> !commit_evt);
endmodule

bind rx_stage_admit rx_stage_admit_chk #(
  .NUM_RINGS(NUM_RINGS), .DEPTH(DEPTH), .OCW(OCW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_apply(cfg_apply), .cfg_tx_pause(cfg_tx_pause),
  .ring_lossless(ring_lossless), .occ_bytes(occ_bytes),
  .out_valid(out_valid), .out_last(out_last),
  .drop_ovf(drop_ovf), .drop_nobuf(drop_nobuf),
  .commit_evt(commit_evt), .ovf_evt(ovf_evt), .release_evt(release_evt),
  .nobuf_evt(nobuf_evt), .head_blocked(head_blocked)
);

// File: tb/rx_stage_admit_tb.sv
`timescale 1ns/1ps
module rx_stage_admit_tb;
  localparam int NR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_tx_pause = 1'b0, cfg_apply = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic [1:0] in_ring = '0;
  logic [NR-1:0] ring_free = '0;
  logic out_valid, out_last, drop_ovf, drop_nobuf;
  logic [7:0] out_data;
  logic [1:0] out_ring;
  logic [6:0] occ_bytes;
  logic [NR-1:0] ring_lossless;

  always #2.5 clk = ~clk;

  rx_stage_admit u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_tx_pause(cfg_tx_pause), .cfg_apply(cfg_apply),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ring(in_ring),
    .ring_free(ring_free), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .out_ring(out_ring), .occ_bytes(occ_bytes),
    .drop_ovf(drop_ovf), .drop_nobuf(drop_nobuf), .ring_lossless(ring_lossless)
  );

  int n_chk = 0, n_err = 0;
  int cap_n = 0, ovf_cnt = 0, nb_cnt = 0, last_cnt = 0;
  logic [7:0] cap_data [1024];
  logic [1:0] cap_ring [1024];

  // Output monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        cap_data[cap_n] = out_data;
        cap_ring[cap_n] = out_ring;
        cap_n++;
        if (out_last) last_cnt++;
      end
      if (drop_ovf) ovf_cnt++;
      if (drop_nobuf) nb_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic apply_cfg(input logic fc);
    cfg_tx_pause = fc;
    cfg_apply = 1'b1;
    tick(1);
    cfg_apply = 1'b0;
  endtask

  task automatic send(input int ring, input int len, input logic [7:0] seed);
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1;
      in_data  = 8'(seed + i);
      in_last  = (i == len - 1);
      in_ring  = 2'(ring);
      tick(1);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic chk_bytes(input int start, input int len, input logic [7:0] seed,
                           input int ring, input string req);
    int bad = 0;
    for (int i = 0; i < len; i++)
      if (cap_data[start+i] !== 8'(seed + i) || cap_ring[start+i] !== 2'(ring)) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  // {ring[21:20], len[19:12], seed[11:4], tx_pause[3], ring_free[2], expect[1:0]}
  // expect: 0 delivered, 1 discarded at head, 2 held then delivered
  localparam logic [21:0] VEC [8] = '{
    {2'd0, 8'd1,  8'h10, 1'b0, 1'b1, 2'd0},
    {2'd1, 8'd32, 8'h20, 1'b0, 1'b1, 2'd0},
    {2'd2, 8'd7,  8'h40, 1'b0, 1'b0, 2'd1},
    {2'd3, 8'd12, 8'h60, 1'b1, 1'b0, 2'd2},
    {2'd0, 8'd5,  8'h80, 1'b1, 1'b1, 2'd0},
    {2'd1, 8'd20, 8'hA0, 1'b1, 1'b0, 2'd2},
    {2'd3, 8'd3,  8'hC0, 1'b0, 1'b0, 2'd1},
    {2'd2, 8'd16, 8'hE0, 1'b0, 1'b1, 2'd0}
  };

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int start, nb0, ov0, lc0;
    tick(4);
    rst_n = 1'b1;
    tick(2);
    // R1 reset state
    chk(occ_bytes == 0, "R1 occupancy", occ_bytes, 0);
    chk(!out_valid && !drop_ovf && !drop_nobuf, "R1 outputs idle", out_valid, 0);
    chk(ring_lossless == '0, "R1 lossy after reset", ring_lossless, 0);

    // R6 pause setting alone changes nothing
    cfg_tx_pause = 1'b1;
    tick(3);
    chk(ring_lossless == '0, "R6 no apply", ring_lossless, 0);
    apply_cfg(1'b1);
    chk(ring_lossless == 4'hF, "R6 apply on", ring_lossless, 15);
    apply_cfg(1'b0);
    chk(ring_lossless == 4'h0, "R6 apply off", ring_lossless, 0);

    // Vector table: R2 R3 R4 R5
    for (int v = 0; v < 8; v++) begin
      int r, ln, ex;
      logic [7:0] sd;
      r  = int'(VEC[v][21:20]);
      ln = int'(VEC[v][19:12]);
      sd = VEC[v][11:4];
      ex = int'(VEC[v][1:0]);
      apply_cfg(VEC[v][3]);
      ring_free = VEC[v][2] ? (NR'(1) << r) : ~(NR'(1) << r);
      start = cap_n;
      nb0 = nb_cnt;
      send(r, ln, sd);
      tick(1);
      if (ex == 2) chk(occ_bytes == 7'(ln), "R3 occupancy after accept", occ_bytes, ln);
      tick(2 * ln + 10);
      if (ex == 0) begin
        chk(cap_n - start == ln, "R2 byte count", cap_n - start, ln);
        chk_bytes(start, ln, sd, r, "R2 bytes and ring");
        chk(occ_bytes == 0, "R3 occupancy after drain", occ_bytes, 0);
      end else if (ex == 1) begin
        chk(cap_n == start, "R4 no output", cap_n - start, 0);
        chk(nb_cnt == nb0 + 1, "R4 discard pulse", nb_cnt - nb0, 1);
        chk(occ_bytes == 0, "R3 occupancy after discard", occ_bytes, 0);
      end else begin
        chk(cap_n == start && nb_cnt == nb0, "R5 held", cap_n - start, 0);
        chk(occ_bytes == 7'(ln), "R5 still counted", occ_bytes, ln);
        ring_free = '1;
        tick(2 * ln + 10);
        chk(cap_n - start == ln, "R5 released count", cap_n - start, ln);
        chk_bytes(start, ln, sd, r, "R5 released bytes");
        chk(occ_bytes == 0, "R3 occupancy after release", occ_bytes, 0);
      end
    end

    // R9 blocked head holds back a frame for a free ring
    apply_cfg(1'b1);
    ring_free = 4'b0010;
    start = cap_n;
    lc0 = last_cnt;
    send(0, 5, 8'h31);
    send(1, 6, 8'h51);
    tick(30);
    chk(cap_n == start, "R9 nothing overtakes", cap_n - start, 0);
    chk(occ_bytes == 11, "R3 two frames held", occ_bytes, 11);
    ring_free = '1;
    tick(40);
    chk(cap_n - start == 11, "R9 total after release", cap_n - start, 11);
    chk_bytes(start, 5, 8'h31, 0, "R9 first frame first");
    chk_bytes(start + 5, 6, 8'h51, 1, "R9 second frame second");
    chk(last_cnt - lc0 == 2, "R2 one last flag per frame", last_cnt - lc0, 2);

    // R7 byte overflow: 30 + 30 held, 10 more would exceed 64
    ring_free = '0;
    start = cap_n;
    ov0 = ovf_cnt;
    send(0, 30, 8'h00);
    send(1, 30, 8'h40);
    send(2, 10, 8'h90);
    tick(5);
    chk(ovf_cnt == ov0 + 1, "R7 overflow pulse", ovf_cnt - ov0, 1);
    chk(occ_bytes == 60, "R7 occupancy unchanged", occ_bytes, 60);
    ring_free = '1;
    tick(100);
    chk(cap_n - start == 60, "R7 refused frame never output", cap_n - start, 60);
    chk_bytes(start, 30, 8'h00, 0, "R7 first kept frame");
    chk_bytes(start + 30, 30, 8'h40, 1, "R7 second kept frame");
    chk(occ_bytes == 0, "R3 empty after overflow run", occ_bytes, 0);

    // R7 descriptor queue full: fifth frame refused
    ring_free = '0;
    start = cap_n;
    ov0 = ovf_cnt;
    for (int k = 0; k < 5; k++) send(k % 4, 2, 8'(8'hB0 + 8'(k * 16)));
    tick(5);
    chk(ovf_cnt == ov0 + 1, "R7 queue-full pulse", ovf_cnt - ov0, 1);
    chk(occ_bytes == 8, "R7 queue-full occupancy", occ_bytes, 8);
    ring_free = '1;
    tick(40);
    chk(cap_n - start == 8, "R7 queue-full output", cap_n - start, 8);
    chk_bytes(start + 6, 2, 8'hE0, 3, "R7 fourth frame last out");

    // R8 one byte over the length limit
    start = cap_n;
    ov0 = ovf_cnt;
    send(0, 33, 8'h01);
    tick(80);
    chk(ovf_cnt == ov0 + 1, "R8 long frame pulse", ovf_cnt - ov0, 1);
    chk(cap_n == start, "R8 long frame not output", cap_n - start, 0);
    chk(occ_bytes == 0, "R8 occupancy", occ_bytes, 0);

    finish_run();
  end
endmodule